// File: doc/BRIEF.md
# BCD Calendar Clock Registers

This block keeps wall-clock time and the calendar in eight byte-wide registers. A host reaches them through a simple byte bus with an address, write data, a write strobe, a read strobe and registered read data. All time fields are held in packed BCD. A periodic `tick` input feeds a prescaler, and every `TICKS_PER_SEC` ticks one second is added. The carry runs through minutes, hours, weekday, date, month and year. Month lengths follow the calendar, and February gets 29 days in leap years.

The eight registers sit at the top of the address space. Offset 0 of the window is control, 1 is seconds, 2 is minutes, 3 is hours, 4 is weekday plus a century flag, 5 is date, 6 is month and 7 is year. The window starts at `2**ADDR_W - 8`. Software can stop the clock through bit 7 of the seconds register and later resume it. Each write is range-checked field by field before it is stored. `YEAR_BASE` sets the century base that the year count is measured from, and the leap-year rule uses that base.

Top module: `bcd_tod_regs`

## Requirements
- R1: Addresses below the window read as 8'hFF. Writes to those addresses change no register in the window.
- R2: `rd_data` takes the value of the addressed register one cycle after a cycle with `rd_en` high. It holds its value while `rd_en` is low.
- R3: A write to offset 0 stores `(data & 8'h5F) | 8'h90`, so bits 7 and 4 read as one and bit 5 reads as zero. This register resets to 8'h90.
- R4: Bit 7 of offset 1 is the stop flag and is written on every seconds write. While it is set, no field advances. Clearing it resumes from the frozen value. A read of offset 1 returns `{stop, seconds[6:0]}`.
- R5: A seconds or minutes write (bits 6:0) is stored only when both nibbles are at most 9 and the value is at most 59.
- R6: An hours write stores bits 5:0 only when they form BCD 0..23. Bits 7:6 are ignored.
- R7: A date write (bits 5:0) is stored only for BCD 1..31. A month write (bits 4:0) is stored only for BCD 1..12. A year write (all 8 bits) is stored only for BCD 0..99.
- R8: Offset 4 stores the weekday from bits 2:0 and a century flag from bit 6 on every write. A read returns `{1'b0, century, 3'b000, weekday}`.
- R9: A second elapses on the `TICKS_PER_SEC`-th tick after the last write to any of offsets 1 to 7. Such a write restarts the count. Ticks in the write cycle itself are not counted.
- R10: Seconds wrap from 59 to 00 into minutes, minutes into hours, and hours from 23 to 00 into the day. The weekday runs from 7 back to 1.
- R11: The date wraps to 01 after the month's last day. April, June, September and November end on the 30th. February ends on the 29th when `(YEAR_BASE + year) % 4 == 0` and on the 28th otherwise. Month 12 wraps to 01 and year 99 wraps to 00.
- R12: After reset the seconds, minutes, hours and year read 00, the weekday, date and month read 01, the century flag is 0 and stop is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| tick | input | 1 | Sub-second timing strobe |

## Verification
The assertions assume that `addr` and `wr_data` are stable whenever `wr_en` is high. They also assume that nothing other than the bus writes to the block, so any change to a field while stopped and idle counts as an error. The stimulus meets this by changing inputs only on the falling edge. It also keeps `tick` low during bus reads, so every read samples a quiescent state. The run counts on the freeze check holding only between writes. For that reason, every resume is done with a deliberately invalid seconds value, which clears the stop flag without reloading the seconds.

// File: rtl/tod_pkg.sv
package tod_pkg;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_SEC  = 3'd1,
      REG_MIN  = 3'd2,
      REG_HOUR = 3'd3,
      REG_WDAY = 3'd4,
      REG_DATE = 3'd5,
      REG_MON  = 3'd6,
      REG_YEAR = 3'd7
   } tod_reg_e;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [2:0] wday;
      logic [5:0] date;
      logic [4:0] mon;
      logic [7:0] year;
   } tod_time_t;

   typedef struct packed {
      logic ctrl;
      logic stop;
      logic sec;
      logic min;
      logic hour;
      logic wday;
      logic date;
      logic mon;
      logic year;
   } tod_load_t;

   // both digits decimal and value inside [lo, hi]
   function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo,
                                   input logic [7:0] hi);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
   parameter int TICKS_PER_SEC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   input  logic clear,
   output logic sec_pulse
);
   localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = &{1'b0, clk, rst_n};
         assign sec_pulse = tick & ~hold & ~clear;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             at_end;
         assign at_end    = (cnt_q == CNT_W'(TICKS_PER_SEC - 1));
         assign sec_pulse = tick & ~hold & ~clear & at_end;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clear)            cnt_q <= '0;
            else if (tick && !hold)    cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/tod_wr_filter.sv
module tod_wr_filter
   import tod_pkg::*;
(
   input  logic      hit,
   input  tod_reg_e  sel,
   input  logic [7:0] wr_data,
   output tod_load_t ld,
   output logic      time_wr
);
   always_comb begin
      ld      = '0;
      time_wr = hit && (sel != REG_CTRL);
      unique case (sel)
         REG_CTRL: ld.ctrl = hit;
         REG_SEC: begin
            ld.stop = hit;
            ld.sec  = hit && bcd_ok({1'b0, wr_data[6:0]}, 8'h00, 8'h59);
         end
         REG_MIN:  ld.min  = hit && bcd_ok({1'b0, wr_data[6:0]}, 8'h00, 8'h59);
         REG_HOUR: ld.hour = hit && bcd_ok({2'b0, wr_data[5:0]}, 8'h00, 8'h23);
         REG_WDAY: ld.wday = hit;
         REG_DATE: ld.date = hit && bcd_ok({2'b0, wr_data[5:0]}, 8'h01, 8'h31);
         REG_MON:  ld.mon  = hit && bcd_ok({3'b0, wr_data[4:0]}, 8'h01, 8'h12);
         REG_YEAR: ld.year = hit && bcd_ok(wr_data, 8'h00, 8'h99);
         default:  ld      = '0;
      endcase
   end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
   import tod_pkg::*;
#(
   parameter int YEAR_BASE = 1900
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       advance,
   input  tod_load_t  ld,
   input  logic [7:0] wr_data,
   output tod_time_t  now
);
   localparam logic [1:0] BASE_MOD4 = 2'(YEAR_BASE % 4);

   tod_time_t  now_q, nxt;
   logic [6:0] year_bin;
   logic       leap;
   logic [5:0] last_day;
   logic       c_min, c_hour, c_day, c_mon, c_year;

   assign year_bin = bcd_to_bin(now_q.year);
   assign leap     = ((year_bin[1:0] + BASE_MOD4) == 2'b00);

   always_comb begin
      unique case (now_q.mon)
         5'h02:                      last_day = leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
         default:                    last_day = 6'h31;
      endcase
   end

   always_comb begin
      nxt    = now_q;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_day  = 1'b0;
      c_mon  = 1'b0;
      c_year = 1'b0;
      if (advance) begin
         if (now_q.sec >= 7'h59) begin nxt.sec = '0; c_min = 1'b1; end
         else nxt.sec = 7'(bcd_inc({1'b0, now_q.sec}));
         if (c_min) begin
            if (now_q.min >= 7'h59) begin nxt.min = '0; c_hour = 1'b1; end
            else nxt.min = 7'(bcd_inc({1'b0, now_q.min}));
         end
         if (c_hour) begin
            if (now_q.hour >= 6'h23) begin nxt.hour = '0; c_day = 1'b1; end
            else nxt.hour = 6'(bcd_inc({2'b0, now_q.hour}));
         end
         if (c_day) begin
            nxt.wday = (now_q.wday == 3'd7) ? 3'd1 : now_q.wday + 3'd1;
            if (now_q.date >= last_day) begin nxt.date = 6'h01; c_mon = 1'b1; end
            else nxt.date = 6'(bcd_inc({2'b0, now_q.date}));
         end
         if (c_mon) begin
            if (now_q.mon >= 5'h12) begin nxt.mon = 5'h01; c_year = 1'b1; end
            else nxt.mon = 5'(bcd_inc({3'b0, now_q.mon}));
         end
         if (c_year) begin
            if (now_q.year >= 8'h99) nxt.year = 8'h00;
            else nxt.year = bcd_inc(now_q.year);
         end
      end
      if (ld.sec)  nxt.sec  = wr_data[6:0];
      if (ld.min)  nxt.min  = wr_data[6:0];
      if (ld.hour) nxt.hour = wr_data[5:0];
      if (ld.wday) nxt.wday = wr_data[2:0];
      if (ld.date) nxt.date = wr_data[5:0];
      if (ld.mon)  nxt.mon  = wr_data[4:0];
      if (ld.year) nxt.year = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q <= '{sec: 7'h00, min: 7'h00, hour: 6'h00, wday: 3'd1,
                    date: 6'h01, mon: 5'h01, year: 8'h00};
      end else begin
         now_q <= nxt;
      end
   end

   assign now = now_q;
endmodule

// File: rtl/bcd_tod_regs.sv
module bcd_tod_regs
   import tod_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int TICKS_PER_SEC = 16,
   parameter int YEAR_BASE     = 1900
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   output logic [7:0]        rd_data,
   input  logic              tick
);
   localparam logic [7:0] CTRL_CLR = 8'hA0;
   localparam logic [7:0] CTRL_SET = 8'h90;

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("bcd_tod_regs: ADDR_W must be at least 4");
      end
      if (TICKS_PER_SEC < 1) begin : g_bad_tps
         $error("bcd_tod_regs: TICKS_PER_SEC must be at least 1");
      end
      if (YEAR_BASE < 0) begin : g_bad_base
         $error("bcd_tod_regs: YEAR_BASE must not be negative");
      end
   endgenerate

   logic       in_win;
   tod_reg_e   sel;
   tod_load_t  ld;
   logic       time_wr;
   logic       sec_pulse;
   tod_time_t  cal_now;
   logic [7:0] ctrl_q;
   logic       stop_q;
   logic       cent_q;
   logic [7:0] rd_mux;

   assign in_win = &addr[ADDR_W-1:3];
   assign sel    = tod_reg_e'(addr[2:0]);

   tod_wr_filter u_filter (
      .hit     (wr_en & in_win),
      .sel     (sel),
      .wr_data (wr_data),
      .ld      (ld),
      .time_wr (time_wr)
   );

   tod_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .hold      (stop_q),
      .clear     (time_wr),
      .sec_pulse (sec_pulse)
   );

   tod_calendar #(.YEAR_BASE(YEAR_BASE)) u_cal (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (sec_pulse),
      .ld      (ld),
      .wr_data (wr_data),
      .now     (cal_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_SET;
         stop_q <= 1'b0;
         cent_q <= 1'b0;
      end else begin
         if (ld.ctrl) ctrl_q <= (wr_data & ~CTRL_CLR) | CTRL_SET;
         if (ld.stop) stop_q <= wr_data[7];
         if (ld.wday) cent_q <= wr_data[6];
      end
   end

   always_comb begin
      if (!in_win) begin
         rd_mux = 8'hFF;
      end else begin
         unique case (sel)
            REG_CTRL: rd_mux = ctrl_q;
            REG_SEC:  rd_mux = {stop_q, cal_now.sec};
            REG_MIN:  rd_mux = {1'b0, cal_now.min};
            REG_HOUR: rd_mux = {2'b0, cal_now.hour};
            REG_WDAY: rd_mux = {1'b0, cent_q, 3'b000, cal_now.wday};
            REG_DATE: rd_mux = {2'b0, cal_now.date};
            REG_MON:  rd_mux = {3'b0, cal_now.mon};
            REG_YEAR: rd_mux = cal_now.year;
            default:  rd_mux = 8'hFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= 8'h00;
      else if (rd_en) rd_data <= rd_mux;
   end
endmodule

// File: rtl/tod_chk.sv
module tod_chk
   import tod_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       in_win,
   input logic [2:0] sel,
   input logic [7:0] wr_data,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input tod_time_t  now,
   input logic       stop,
   input logic [7:0] ctrl
);
   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R3
   ctrl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && sel == 3'd0) |=> (ctrl[7] && ctrl[4] && !ctrl[5]));

   // R4
   stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !wr_en) |=> $stable(now));

   // R5
   sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now.sec[3:0] <= 4'd9) && (now.sec <= 7'h59) && (now.min[3:0] <= 4'd9) && (now.min <= 7'h59));

   // R5
   bad_sec_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && sel == 3'd1 && wr_data[3:0] > 4'd9) |=> $stable(now.sec));

   // R6
   hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now.hour[3:0] <= 4'd9) && (now.hour <= 6'h23));

   // R7
   mon_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now.mon != 5'h00) && (now.mon <= 5'h12) && (now.date != 6'h00));
endmodule

bind bcd_tod_regs tod_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .in_win  (in_win),
   .sel     (addr[2:0]),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .now     (cal_now),
   .stop    (stop_q),
   .ctrl    (ctrl_q)
);

// File: tb/sim_bcd_tod_regs.sv
`timescale 1ns/1ps
module sim_bcd_tod_regs;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 13;
   localparam int TPS  = 4;
   localparam int BASE = (1 << AW) - 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic          rd_en = 1'b0;
   logic [7:0]    rd_data;
   logic          tick = 1'b0;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R12";

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_tod_regs #(.ADDR_W(AW), .TICKS_PER_SEC(TPS), .YEAR_BASE(1968)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .tick(tick)
   );

   // ---------------- behavioural reference (binary state) ----------------
   int m_ctrl, m_sec, m_min, m_hr, m_wday, m_date, m_mon, m_yr, m_stop, m_cent, m_pre, m_rd;

   function automatic int tobcd(int v); return (v / 10) * 16 + v % 10; endfunction
   function automatic int frombcd(int v); return (v / 16) * 10 + v % 16; endfunction
   function automatic bit okbcd(int v, int lo, int hi);
      return (v % 16 <= 9) && (v / 16 <= 9) && (frombcd(v) >= lo) && (frombcd(v) <= hi);
   endfunction
   function automatic int mdays(int mo, int yr);
      if (mo == 2) return ((1968 + yr) % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic int m_read(int a);
      if (a < BASE) return 8'hFF;
      case (a - BASE)
         0: return m_ctrl;
         1: return m_stop * 128 + tobcd(m_sec);
         2: return tobcd(m_min);
         3: return tobcd(m_hr);
         4: return m_cent * 64 + m_wday;
         5: return tobcd(m_date);
         6: return tobcd(m_mon);
         default: return tobcd(m_yr);
      endcase
   endfunction

   task automatic m_second();
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0; m_min++;
      if (m_min < 60) return;
      m_min = 0; m_hr++;
      if (m_hr < 24) return;
      m_hr = 0;
      m_wday = (m_wday >= 7) ? 1 : m_wday + 1;
      if (m_date >= mdays(m_mon, m_yr)) begin
         m_date = 1; m_mon++;
         if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
      end else m_date++;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 8'h90; m_sec = 0; m_min = 0; m_hr = 0; m_wday = 1; m_date = 1;
         m_mon = 1; m_yr = 0; m_stop = 0; m_cent = 0; m_pre = 0; m_rd = 0;
      end else begin
         int a, d;
         bit tw;
         a = int'(addr); d = int'(wr_data);
         tw = 1'b0;
         if (rd_en) m_rd = m_read(a);
         if (wr_en && a >= BASE) begin
            tw = (a - BASE) != 0;
            case (a - BASE)
               0: m_ctrl = (d & 8'h5F) | 8'h90;
               1: begin m_stop = d / 128; if (okbcd(d % 128, 0, 59)) m_sec = frombcd(d % 128); end
               2: if (okbcd(d % 128, 0, 59)) m_min = frombcd(d % 128);
               3: if (okbcd(d % 64, 0, 23)) m_hr = frombcd(d % 64);
               4: begin m_wday = d % 8; m_cent = (d / 64) % 2; end
               5: if (okbcd(d % 64, 1, 31)) m_date = frombcd(d % 64);
               6: if (okbcd(d % 32, 1, 12)) m_mon = frombcd(d % 32);
               default: if (okbcd(d, 0, 99)) m_yr = frombcd(d);
            endcase
         end
         if (tw) m_pre = 0;
         else if (tick && m_stop == 0) begin
            m_pre++;
            if (m_pre == TPS) begin m_pre = 0; m_second(); end
         end
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (int'(rd_data) != m_rd) begin
            n_fail++;
            $display("FAIL %s model compare: rd_data actual %h expected %h", cur_req, rd_data, m_rd[7:0]);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(int off, int d);
      @(negedge clk); addr = AW'(BASE + off); wr_data = 8'(d); wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wr_abs(int a, int d);
      @(negedge clk); addr = AW'(a); wr_data = 8'(d); wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_abs(int a, int exp, string tag);
      @(negedge clk); addr = AW'(a); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      n_chk++;
      if (int'(rd_data) != exp) begin
         n_fail++;
         $display("FAIL %s addr %h: actual %h expected %h", tag, a, rd_data, exp[7:0]);
      end
   endtask

   task automatic rd(int off, int exp, string tag);
      rd_abs(BASE + off, exp, tag);
   endtask

   task automatic run_ticks(int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_time(int yr, int mo, int dt, int hr, int mi, int se);
      wr(7, yr); wr(6, mo); wr(5, dt); wr(3, hr); wr(2, mi); wr(1, se);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset values
      cur_req = "R12";
      rd(0, 8'h90, "R12"); rd(1, 8'h00, "R12"); rd(2, 8'h00, "R12"); rd(3, 8'h00, "R12");
      rd(4, 8'h01, "R12"); rd(5, 8'h01, "R12"); rd(6, 8'h01, "R12"); rd(7, 8'h00, "R12");
      // R1 outside window
      cur_req = "R1";
      rd_abs(16'h0010, 8'hFF, "R1");
      rd_abs(BASE - 1, 8'hFF, "R1");
      wr_abs(BASE - 7, 8'h33);
      rd(1, 8'h00, "R1");
      rd(0, 8'h90, "R1");
      // R3 control forcing
      cur_req = "R3";
      wr(0, 8'hFF); rd(0, 8'hDF, "R3");
      wr(0, 8'h00); rd(0, 8'h90, "R3");
      wr(0, 8'h25); rd(0, 8'h95, "R3");
      // R5 seconds / minutes range
      cur_req = "R5";
      wr(1, 8'h45); rd(1, 8'h45, "R5");
      wr(1, 8'h5A); rd(1, 8'h45, "R5");
      wr(1, 8'h60); rd(1, 8'h45, "R5");
      wr(2, 8'h59); rd(2, 8'h59, "R5");
      wr(2, 8'h7A); rd(2, 8'h59, "R5");
      // R6 hours
      cur_req = "R6";
      wr(3, 8'h23); rd(3, 8'h23, "R6");
      wr(3, 8'h24); rd(3, 8'h23, "R6");
      wr(3, 8'hC5); rd(3, 8'h05, "R6");
      // R7 date / month / year
      cur_req = "R7";
      wr(5, 8'h00); rd(5, 8'h01, "R7");
      wr(5, 8'h31); rd(5, 8'h31, "R7");
      wr(5, 8'h32); rd(5, 8'h31, "R7");
      wr(6, 8'h00); rd(6, 8'h01, "R7");
      wr(6, 8'h13); rd(6, 8'h01, "R7");
      wr(6, 8'hE9); rd(6, 8'h09, "R7");
      wr(7, 8'h99); rd(7, 8'h99, "R7");
      wr(7, 8'hA0); rd(7, 8'h99, "R7");
      // R8 weekday and century
      cur_req = "R8";
      wr(4, 8'h47); rd(4, 8'h47, "R8");
      wr(4, 8'hB3); rd(4, 8'h03, "R8");
      // R2 read data holds without strobe
      cur_req = "R2";
      rd(2, 8'h59, "R2");
      wr(2, 8'h12);
      repeat (2) @(negedge clk);
      n_chk++;
      if (rd_data != 8'h59) begin
         n_fail++;
         $display("FAIL R2 hold: actual %h expected 59", rd_data);
      end
      // R9 prescaler and restart on write
      cur_req = "R9";
      wr(1, 8'h10);
      run_ticks(3); rd(1, 8'h10, "R9");
      run_ticks(1); rd(1, 8'h11, "R9");
      run_ticks(2); wr(2, 8'h05);
      run_ticks(3); rd(1, 8'h11, "R9");
      run_ticks(1); rd(1, 8'h12, "R9");
      // R4 stop and resume
      cur_req = "R4";
      wr(1, 8'hB0);
      run_ticks(8); rd(1, 8'hB0, "R4"); rd(2, 8'h05, "R4");
      wr(1, 8'h7F); rd(1, 8'h30, "R4");
      run_ticks(4); rd(1, 8'h31, "R4");
      // R10 full day carry and weekday wrap
      cur_req = "R10";
      wr(4, 8'h47);
      set_time(8'h10, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59);
      run_ticks(4);
      rd(1, 8'h00, "R10"); rd(2, 8'h00, "R10"); rd(3, 8'h00, "R10");
      rd(4, 8'h41, "R10"); rd(5, 8'h16, "R10"); rd(6, 8'h06, "R10");
      set_time(8'h10, 8'h06, 8'h16, 8'h10, 8'h59, 8'h59);
      run_ticks(4); rd(3, 8'h11, "R10"); rd(2, 8'h00, "R10");
      // R11 month lengths, leap years, year wrap
      cur_req = "R11";
      set_time(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      run_ticks(4); rd(5, 8'h01, "R11"); rd(6, 8'h03, "R11");
      set_time(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      run_ticks(4); rd(5, 8'h29, "R11"); rd(6, 8'h02, "R11");
      wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h59);
      run_ticks(4); rd(5, 8'h01, "R11"); rd(6, 8'h03, "R11");
      set_time(8'h20, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
      run_ticks(4); rd(5, 8'h01, "R11"); rd(6, 8'h05, "R11");
      set_time(8'h20, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59);
      run_ticks(4); rd(5, 8'h31, "R11"); rd(6, 8'h01, "R11");
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
      run_ticks(4); rd(5, 8'h01, "R11"); rd(6, 8'h01, "R11"); rd(7, 8'h00, "R11");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule